// File: doc/BRIEF.md
# Display Peripheral Read-Response Parser

After the host hands the serial display link over to a peripheral, the peripheral sends back a short burst of 32-bit words. A receive FIFO holds these words. This block takes them in over a valid/ready word interface. It classifies the response from the data type in the first word, then produces one of three results: the error flags of an acknowledge report, the one or two bytes of a short read, or the payload of a long read. Payload is turned into a plain byte stream, and that stream is limited to a byte budget the requester gives at start.

A transaction begins with a one-cycle `start`. Together with `start` the requester presents two values: the number of FIFO words that belong to this response (`word_cnt`) and the largest number of bytes it wants back (`max_len`). The block consumes exactly `word_cnt` words. Any word it does not need is drained and thrown away. It then pulses `done`. The error vector, the byte count and the protocol-error flag keep their values from `done` until the next accepted `start`.

Both data interfaces follow valid/ready rules. A word transfers on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` never depends on `in_valid`. A byte transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and the last flag stay unchanged. Back-pressure on the byte side stalls word intake, so no word is lost.

Top module: `dsi_resp_parser`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `done`, `proto_err`, `err_vec` and `byte_cnt` are all zero.
- R2: The response kind is taken from bits 5:0 of the first word. 0x02 is an acknowledge/error report, 0x21 a one-byte short read, 0x22 a two-byte short read, and 0x1C and 0x1A are long reads.
- R3: For an acknowledge report, `err_vec` takes bits 23:8 of the first word, with bit 14 (reserved) forced to zero. No bytes are produced.
- R4: A one-byte short read yields bits 15:8 of the first word. A two-byte short read yields bits 15:8 and then bits 23:16. Either one is cut to `max_len` bytes.
- R5: A long read takes its byte count from bits 23:8 of the first word. Its payload bytes come from the following words, least significant byte first, four per word.
- R6: The number of bytes delivered is the smallest of the decoded size and `max_len`. For long reads it is also capped at four times the number of payload words present (`word_cnt` - 1). `byte_cnt` equals the number delivered.
- R7: Any other data type sets `proto_err`, leaves `err_vec` at zero and produces no bytes.
- R8: Exactly `word_cnt` words are accepted per transaction. Words beyond what is needed are accepted and discarded. With `word_cnt` = 0, no word is accepted.
- R9: `out_last` is high on the final delivered byte and on no other byte.
- R10: `done` is high for exactly one cycle, after the last word is accepted and the last byte is taken. Results stay unchanged afterwards, and a `start` given while a transaction is in progress is ignored.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transaction; only sampled when idle |
| word_cnt | input | 5 | Number of FIFO words in this response |
| max_len | input | 16 | Byte budget of the requester |
| in_data | input | 32 | Word from the receive FIFO |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Parser accepts a word |
| out_byte | output | 8 | Delivered data byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_last | output | 1 | Marks the final byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err_vec | output | 16 | Error flags from an acknowledge report |
| byte_cnt | output | 16 | Bytes delivered in this transaction |
| proto_err | output | 1 | Unrecognised response data type |

## Verification
The hardest situation to reach is a long read whose budget or word supply runs out partway through a word, while the consumer is stalling and surplus words are still waiting to be drained. The stimulus reaches it by drawing the word count, the budget and extra leftover words independently from $urandom, so that the cut-off falls at every byte position within a word. Words and bytes are throttled randomly on both sides. Directed cases add a response with fewer payload words than its header claims, a zero budget, a zero word count, a reserved error bit set, and a `start` sent in the middle of a transaction.

// File: rtl/dsirp_pkg.sv
package dsirp_pkg;
  localparam int HDR_W   = 32;
  localparam int FIELD_W = 16;
  localparam int FIELD_LSB = 8;
  localparam int RSVD_ERR_BIT = 14;

  localparam logic [5:0] DT_ACK_ERR    = 6'h02;
  localparam logic [5:0] DT_DCS_SHORT1 = 6'h21;
  localparam logic [5:0] DT_DCS_SHORT2 = 6'h22;
  localparam logic [5:0] DT_DCS_LONG   = 6'h1C;
  localparam logic [5:0] DT_GEN_LONG   = 6'h1A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_FETCH, ST_EMIT, ST_DRAIN, ST_FIN
  } rp_state_e;

  typedef enum logic [2:0] {
    K_ACK, K_SHORT1, K_SHORT2, K_LONG, K_BAD
  } rp_kind_e;
endpackage

// File: rtl/dsirp_hdr_decode.sv
module dsirp_hdr_decode
  import dsirp_pkg::*;
(
  input  logic [HDR_W-1:0]   hdr_i,
  output rp_kind_e           kind_o,
  output logic [FIELD_W-1:0] field_o,
  output logic [FIELD_W-1:0] err_o
);
  logic [5:0] dt;

  assign dt      = hdr_i[5:0];
  assign field_o = hdr_i[FIELD_LSB +: FIELD_W];

  always_comb begin
    err_o = field_o;
    err_o[RSVD_ERR_BIT] = 1'b0;
  end

  always_comb begin
    unique case (dt)
      DT_ACK_ERR:                kind_o = K_ACK;
      DT_DCS_SHORT1:             kind_o = K_SHORT1;
      DT_DCS_SHORT2:             kind_o = K_SHORT2;
      DT_DCS_LONG, DT_GEN_LONG:  kind_o = K_LONG;
      default:                   kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/dsirp_unpack.sv
module dsirp_unpack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              adv_i,
  output logic [7:0]        byte_o,
  output logic              at_end_o
);
  localparam int BPW   = WORD_W / 8;
  localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BPW - 1);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      idx_q  <= '0;
    end else if (adv_i) begin
      word_q <= word_q >> 8;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign byte_o   = word_q[7:0];
  assign at_end_o = (idx_q == IDX_END);
endmodule

// File: rtl/dsi_resp_parser.sv
module dsi_resp_parser
  import dsirp_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [HDR_W-1:0]  in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              done,
  output logic [FIELD_W-1:0] err_vec,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic              proto_err
);
  rp_state_e          st_q;
  logic [CNT_W-1:0]   left_q;
  logic [LEN_W-1:0]   cap_q, rem_q, cnt_q;
  logic [FIELD_W-1:0] err_q;
  logic               proto_q, is_long_q;

  rp_kind_e           kind;
  logic [FIELD_W-1:0] field, err_field;
  logic [LEN_W-1:0]   short_n, long_n;
  logic               in_hs, out_hs, last_byte, at_end, load;
  logic [HDR_W-1:0]   load_word;

  function automatic logic [LEN_W-1:0] clamp(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? LEN_W'(a) : LEN_W'(b);
  endfunction

  dsirp_hdr_decode u_dec (
    .hdr_i   (in_data),
    .kind_o  (kind),
    .field_o (field),
    .err_o   (err_field)
  );

  assign short_n = clamp((kind == K_SHORT2) ? 32'd2 : 32'd1, 32'(cap_q));
  assign long_n  = clamp(32'(field), 32'(cap_q));

  assign in_ready  = (st_q == ST_HDR) || (st_q == ST_FETCH) ||
                     ((st_q == ST_DRAIN) && (left_q != '0));
  assign in_hs     = in_valid && in_ready;
  assign out_valid = (st_q == ST_EMIT);
  assign out_hs    = out_valid && out_ready;
  assign last_byte = (rem_q == LEN_W'(1)) || (is_long_q && at_end && (left_q == '0));
  assign out_last  = out_valid && last_byte;
  assign done      = (st_q == ST_FIN);
  assign err_vec   = err_q;
  assign byte_cnt  = cnt_q;
  assign proto_err = proto_q;

  assign load      = in_hs && (((st_q == ST_HDR) && ((kind == K_SHORT1) || (kind == K_SHORT2)))
                               || (st_q == ST_FETCH));
  assign load_word = (st_q == ST_HDR) ? (in_data >> 8) : in_data;

  dsirp_unpack #(.WORD_W(HDR_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .word_i   (load_word),
    .adv_i    (out_hs),
    .byte_o   (out_byte),
    .at_end_o (at_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      left_q    <= '0;
      cap_q     <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      err_q     <= '0;
      proto_q   <= 1'b0;
      is_long_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          left_q    <= word_cnt;
          cap_q     <= max_len;
          rem_q     <= '0;
          cnt_q     <= '0;
          err_q     <= '0;
          proto_q   <= 1'b0;
          is_long_q <= 1'b0;
          st_q      <= (word_cnt == '0) ? ST_FIN : ST_HDR;
        end
        ST_HDR: if (in_hs) begin
          left_q <= left_q - 1'b1;
          unique case (kind)
            K_ACK: begin
              err_q <= err_field;
              st_q  <= ST_DRAIN;
            end
            K_SHORT1, K_SHORT2: begin
              rem_q     <= short_n;
              is_long_q <= 1'b0;
              st_q      <= (short_n != '0) ? ST_EMIT : ST_DRAIN;
            end
            K_LONG: begin
              rem_q     <= long_n;
              is_long_q <= 1'b1;
              st_q      <= ((long_n != '0) && (left_q != CNT_W'(1))) ? ST_FETCH : ST_DRAIN;
            end
            default: begin
              proto_q <= 1'b1;
              st_q    <= ST_DRAIN;
            end
          endcase
        end
        ST_FETCH: if (in_hs) begin
          left_q <= left_q - 1'b1;
          st_q   <= ST_EMIT;
        end
        ST_EMIT: if (out_hs) begin
          rem_q <= rem_q - 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (last_byte)               st_q <= ST_DRAIN;
          else if (is_long_q && at_end) st_q <= ST_FETCH;
        end
        ST_DRAIN: begin
          if (left_q == '0)  st_q   <= ST_FIN;
          else if (in_hs)    left_q <= left_q - 1'b1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_WORDS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (left_q == '0)); // R8
  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vec[RSVD_ERR_BIT]); // R3
  AST_PROTO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !out_valid); // R7
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= cap_q); // R6
endmodule

// File: tb/dsi_resp_parser_tb.sv
`timescale 1ns/1ps
module dsi_resp_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  word_cnt = '0;
  logic [15:0] max_len = '0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_last;
  logic        done;
  logic [15:0] err_vec;
  logic [15:0] byte_cnt;
  logic        proto_err;

  always #2.5 clk = ~clk;

  dsi_resp_parser u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_cnt(word_cnt), .max_len(max_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .done(done), .err_vec(err_vec), .byte_cnt(byte_cnt), .proto_err(proto_err)
  );

  int checks = 0;
  int errors = 0;
  int total_cyc = 0;

  logic [31:0] mem [0:47];
  logic [7:0]  exp_b [0:255];
  int          exp_n;
  logic [15:0] exp_err;
  bit          exp_proto;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit dt_known(input logic [5:0] d);
    return (d == 6'h02) || (d == 6'h21) || (d == 6'h22) || (d == 6'h1C) || (d == 6'h1A);
  endfunction

  task automatic fill_garbage(input int from);
    for (int i = from; i < 48; i++) mem[i] = $urandom;
  endtask

  task automatic run_txn(input int nw, input int ml, input bit poke);
    int ptr = 0;
    int got = 0;
    int cyc = 0;
    bit fin = 0;
    @(negedge clk);
    start = 1'b1; word_cnt = nw[4:0]; max_len = ml[15:0];
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 3000) begin
      in_valid  = (ptr < nw + 2) && ($urandom % 4 != 0);
      in_data   = mem[ptr];
      out_ready = ($urandom % 3 != 0);
      start     = poke && (cyc == 2);
      if (start) begin word_cnt = 5'd7; max_len = 16'd1; end
      #1;
      if (in_valid && in_ready) ptr++;
      if (out_valid && out_ready) begin
        // R4 R5: byte order and content
        chk(got < exp_n, "R6 byte beyond expected count", got, exp_n);
        if (got < exp_n) begin
          chk(out_byte == exp_b[got], "R5 payload byte", out_byte, exp_b[got]);
          chk(out_last == (got == exp_n - 1), "R9 last flag", out_last, got == exp_n - 1);
        end
        got++;
      end
      if (done) fin = 1;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    chk(fin, "R10 done seen", fin, 1);
    chk(ptr == nw, "R8 words accepted", ptr, nw);
    chk(got == exp_n, "R6 bytes delivered", got, exp_n);
    chk(byte_cnt == exp_n[15:0], "R6 byte_cnt", byte_cnt, exp_n);
    chk(err_vec == exp_err, "R3 err_vec", err_vec, exp_err);
    chk(proto_err == exp_proto, "R7 proto_err", proto_err, exp_proto);
    #1;
    chk(!done, "R10 done single cycle", done, 0);
    @(negedge clk);
    #1;
    chk(byte_cnt == exp_n[15:0] && err_vec == exp_err && proto_err == exp_proto,
        "R10 results held", byte_cnt, exp_n);
  endtask

  task automatic do_long(input logic [5:0] dt, input int wc, input int extra,
                         input int trunc_to, input int ml, input bit poke);
    int nw = 1 + (wc + 3) / 4 + extra;
    if (trunc_to >= 0) nw = trunc_to;
    if (nw > 31) nw = 31;
    fill_garbage(0);
    mem[0] = {8'($urandom), wc[15:0], 2'($urandom), dt};
    exp_n = imin(imin(wc, ml), 4 * (nw - 1));
    for (int i = 0; i < exp_n; i++) exp_b[i] = mem[1 + i / 4][8 * (i % 4) +: 8];
    exp_err = '0; exp_proto = 0;
    run_txn(nw, ml, poke);
  endtask

  task automatic do_short(input bit two, input int ml, input int extra);
    logic [15:0] d = 16'($urandom);
    fill_garbage(0);
    mem[0] = {8'($urandom), d, 2'($urandom), two ? 6'h22 : 6'h21};
    exp_n = imin(two ? 2 : 1, ml);
    exp_b[0] = d[7:0]; exp_b[1] = d[15:8];
    exp_err = '0; exp_proto = 0;
    run_txn(1 + extra, ml, 0);
  endtask

  task automatic do_ack(input logic [15:0] e, input int extra);
    fill_garbage(0);
    mem[0] = {8'($urandom), e, 2'($urandom), 6'h02};
    exp_n = 0; exp_err = e & ~16'h4000; exp_proto = 0;
    run_txn(1 + extra, 40, 0);
  endtask

  task automatic do_bad(input logic [5:0] dt, input int extra);
    fill_garbage(0);
    mem[0] = {$urandom, dt};
    mem[0][5:0] = dt;
    exp_n = 0; exp_err = '0; exp_proto = 1;
    run_txn(1 + extra, 40, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_garbage(0);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!in_ready && !out_valid && !done, "R1 handshake idle", {in_ready, out_valid, done}, 0);
    chk(err_vec == 0 && byte_cnt == 0 && !proto_err, "R1 results zero", byte_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    exp_n = 0; exp_err = '0; exp_proto = 0;
    run_txn(0, 10, 0);                         // R8 zero words
    do_ack(16'hFFFF, 2);                       // R3 reserved bit cleared
    do_ack(16'h0301, 0);                       // R3
    do_short(0, 5, 0);                         // R4 one byte
    do_short(1, 5, 1);                         // R4 two bytes, leftover
    do_short(1, 1, 0);                         // R4 cut to budget
    do_short(0, 0, 0);                         // R6 zero budget
    do_long(6'h1C, 13, 0, -1, 100, 0);         // R5 DCS long
    do_long(6'h1A, 20, 2, -1, 6, 0);           // R6 budget mid-word, drain
    do_long(6'h1A, 20, 0, 3, 100, 0);          // R6 truncated word supply
    do_long(6'h1C, 0, 1, -1, 20, 0);           // R5 zero length
    do_long(6'h1C, 12, 1, -1, 12, 1);          // R10 start while busy ignored
    do_bad(6'h11, 1);                          // R7
    do_bad(6'h00, 0);                          // R7, R2

    // Random mix
    for (int t = 0; t < 60; t++) begin
      int k = $urandom % 6;
      case (k)
        0: do_ack(16'($urandom), $urandom % 3);
        1: do_short(0, $urandom % 3, $urandom % 3);
        2: do_short(1, $urandom % 3, $urandom % 3);
        3, 4: do_long((($urandom % 2) != 0) ? 6'h1C : 6'h1A, $urandom % 61, $urandom % 3,
                      (($urandom % 8) == 0) ? int'($urandom % 4) + 1 : -1, $urandom % 61, 0);
        default: begin
          logic [5:0] d = 6'($urandom);
          while (dt_known(d)) d = 6'($urandom);
          do_bad(d, $urandom % 3);
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule